// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame that carries a group destination address should be accepted. The six destination-address bytes stream in one per cycle. The block runs an Ethernet CRC-32 over them and reduces the result to an 8-bit hash. That hash picks one bit of a 256-entry filter table, and the selected bit is the accept decision.

The table is held as eight 32-bit registers. Host software owns these registers through a small command port, which offers three operations:
- a whole-word write;
- setting one table entry, which joins a group;
- clearing one table entry, which leaves a group.

A combinational read port returns any selected register. Frames whose destination is an individual address are passed through with a valid strobe and a reject. Exact-match unicast filtering and promiscuous policy belong to the surrounding receive path.

Top module: `mcast_hash_filter`

## Requirements
- R1: The CRC starts at 0xFFFFFFFF for each address and takes every byte low bit first using the reflected polynomial 0xEDB88320. No final inversion is applied. The hash is bits 31..24 of the bit-reversed CRC, so hash bit 7 is CRC bit 0 and hash bit 0 is CRC bit 7.
- R2: Hash bits 7..5 select table register 0..7. Hash bits 4..0 give a value k, and the entry is bit position 31-k of that register. Entry 0 is therefore bit 31 of register 0, and entry 255 is bit 0 of register 7.
- R3: After reset all eight table registers read zero, and no group frame matches.
- R4: Command 2 (set) with entry index e sets exactly table entry e, on the clock edge where the command is sampled. All other bits are unchanged.
- R5: Command 3 (clear) with entry index e clears exactly table entry e. All other bits are unchanged.
- R6: Command 1 (word write) replaces register reg_sel_i with reg_wdata_i. reg_rdata_o shows register reg_sel_i combinationally.
- R7: The group flag is bit 0 of the first address byte. When this flag is 0, the frame still produces a match_valid_o pulse, and match_o stays 0 whatever the table holds.
- R8: match_valid_o is high for exactly one cycle. That cycle starts at the clock edge that absorbs the sixth byte. During it, match_o equals the indexed table bit for a group frame.
- R9: A byte presented with addr_first_i high restarts the computation from all ones and discards any partial address in progress.
- R10: Bytes presented without addr_first_i outside a frame are ignored and produce no match_valid_o pulse. This covers bytes sent before any first byte and bytes sent after the sixth.
- R11: Command 0 (idle) leaves every table register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_valid_i | input | 1 | Address byte present this cycle |
| addr_first_i | input | 1 | Byte is the first of a destination address |
| addr_byte_i | input | 8 | Destination-address byte, in wire order |
| match_valid_o | output | 1 | One-cycle decision strobe |
| match_o | output | 1 | Accept decision, meaningful with match_valid_o |
| reg_cmd_i | input | 2 | 0 idle, 1 word write, 2 set entry, 3 clear entry |
| reg_sel_i | input | 3 | Register select for word write and read |
| reg_entry_i | input | 8 | Table entry index for set and clear |
| reg_wdata_i | input | 32 | Word write data |
| reg_rdata_o | output | 32 | Read data of register reg_sel_i |

## Verification
The bench sweeps every one of the 256 entries and every register, so it catches these errors:
- a reversed bit order inside a register, which would light up position k instead of 31-k;
- a swapped register/bit split of the hash, which would land the bit in the wrong register.

For 256 group addresses the bench enables only the entry it computes itself from the CRC. A design that inverts the CRC, omits the reversal, or shifts most-significant bit first then misses the match.

Further cases check the following:
- A clear must spare the other 31 bits of a fully set register; an overbroad mask shows up as missing ones.
- An individual address must be rejected even when the table is all ones.
- An abandoned partial address must not leak into the following frame's hash.
- Stray bytes outside a frame must not raise a strobe.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_WORD = 2'd1,
    CMD_SET  = 2'd2,
    CMD_CLR  = 2'd3
  } cmd_e;

  // one byte through the reflected CRC, low bit first
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/mhf_crc.sv
module mhf_crc #(
  parameter int HASH_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              load_i,
  input  logic [7:0]        byte_i,
  output logic [HASH_W-1:0] hash_o
);
  import mhf_pkg::*;

  logic [31:0] crc_q;
  logic [31:0] crc_base;

  assign crc_base = load_i ? 32'hFFFF_FFFF : crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= 32'hFFFF_FFFF;
    else if (step_i) crc_q <= crc_byte(crc_base, byte_i);
  end

  // top HASH_W bits of the fully reversed register
  for (genvar g = 0; g < HASH_W; g++) begin : g_rev
    assign hash_o[HASH_W-1-g] = crc_q[g];
  end
endmodule

// File: rtl/mhf_table.sv
module mhf_table #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 32,
  localparam int SEL_W   = $clog2(NUM_REGS),
  localparam int BIT_W   = $clog2(REG_W),
  localparam int IDX_W   = SEL_W + BIT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cmd_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [IDX_W-1:0] entry_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic [IDX_W-1:0] lkp_idx_i,
  output logic             lkp_bit_o
);
  import mhf_pkg::*;

  logic [REG_W-1:0] tbl_q [NUM_REGS];
  logic [REG_W-1:0] mask;
  logic [BIT_W-1:0] ent_pos, lkp_pos;
  logic [NUM_REGS*REG_W-1:0] tbl_flat;

  // entries are numbered from the MSB down
  assign ent_pos = BIT_W'(REG_W-1) - entry_i[BIT_W-1:0];
  assign lkp_pos = BIT_W'(REG_W-1) - lkp_idx_i[BIT_W-1:0];
  assign mask    = {{(REG_W-1){1'b0}}, 1'b1} << ent_pos;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit_ent, hit_sel;
    assign hit_ent = (entry_i[IDX_W-1:BIT_W] == SEL_W'(g));
    assign hit_sel = (sel_i == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tbl_q[g] <= '0;
      else begin
        unique case (cmd_e'(cmd_i))
          CMD_WORD: if (hit_sel) tbl_q[g] <= wdata_i;
          CMD_SET:  if (hit_ent) tbl_q[g] <= tbl_q[g] | mask;
          CMD_CLR:  if (hit_ent) tbl_q[g] <= tbl_q[g] & ~mask;
          default:  ;
        endcase
      end
    end

    assign tbl_flat[g*REG_W +: REG_W] = tbl_q[g];
  end

  assign rdata_o   = tbl_q[sel_i];
  assign lkp_bit_o = tbl_q[lkp_idx_i[IDX_W-1:BIT_W]][lkp_pos];

  p_idle_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_IDLE |=> $stable(tbl_flat));

  p_set_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_SET |=> ($countones(tbl_flat ^ $past(tbl_flat)) <= 1)
                         && ((tbl_flat & $past(tbl_flat)) == $past(tbl_flat)));

  p_clr_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_CLR |=> ($countones(tbl_flat ^ $past(tbl_flat)) <= 1)
                         && ((tbl_flat | $past(tbl_flat)) == $past(tbl_flat)));
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int NUM_REGS   = 8,
  parameter int REG_W      = 32,
  localparam int SEL_W     = $clog2(NUM_REGS),
  localparam int IDX_W     = SEL_W + $clog2(REG_W),
  localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             addr_valid_i,
  input  logic             addr_first_i,
  input  logic [7:0]       addr_byte_i,
  output logic             match_valid_o,
  output logic             match_o,
  input  logic [1:0]       reg_cmd_i,
  input  logic [SEL_W-1:0] reg_sel_i,
  input  logic [IDX_W-1:0] reg_entry_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             absorb, start;
  logic             done_q, grp_q;
  logic [IDX_W-1:0] hash;
  logic             tbl_bit;

  assign start  = addr_valid_i & addr_first_i;
  assign absorb = start | (addr_valid_i & (cnt_q != '0) & (cnt_q != LAST));

  always_comb begin
    cnt_d = cnt_q;
    if (start)       cnt_d = CNT_W'(1);
    else if (absorb) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      grp_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= absorb & (cnt_d == LAST);
      if (start) grp_q <= addr_byte_i[0];
    end
  end

  mhf_crc #(.HASH_W(IDX_W)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (absorb),
    .load_i (start),
    .byte_i (addr_byte_i),
    .hash_o (hash)
  );

  mhf_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (reg_cmd_i),
    .sel_i     (reg_sel_i),
    .entry_i   (reg_entry_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .lkp_idx_i (hash),
    .lkp_bit_o (tbl_bit)
  );

  assign match_valid_o = done_q;
  assign match_o       = done_q & grp_q & tbl_bit;

  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_valid_o |=> !match_valid_o);

  p_match_needs_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> match_valid_o);

  p_stray_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_i && !addr_first_i && (cnt_q == '0 || cnt_q == LAST)) |=> !match_valid_o);
endmodule

// File: tb/tb_mcast_hash_filter.sv
module tb_mcast_hash_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        av = 1'b0, af = 1'b0;
  logic [7:0]  ab = '0;
  logic        mv, m;
  logic [1:0]  cmd = 2'd0;
  logic [2:0]  sel = '0;
  logic [7:0]  ent = '0;
  logic [31:0] wd = '0, rd;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mcast_hash_filter dut (
    .clk_i(clk), .rst_ni(rst_n),
    .addr_valid_i(av), .addr_first_i(af), .addr_byte_i(ab),
    .match_valid_o(mv), .match_o(m),
    .reg_cmd_i(cmd), .reg_sel_i(sel), .reg_entry_i(ent),
    .reg_wdata_i(wd), .reg_rdata_o(rd)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_hash(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0]  h;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++)
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ a[47 - 8*i - 7 + b];
        c  = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB88320;
      end
    for (int b = 0; b < 8; b++) h[7-b] = c[b];
    return h;
  endfunction

  task automatic op(input logic [1:0] c, input logic [2:0] s, input logic [7:0] e, input logic [31:0] d);
    @(negedge clk); cmd = c; sel = s; ent = e; wd = d;
    @(negedge clk); cmd = 2'd0;
  endtask

  task automatic rdreg(input logic [2:0] s, output logic [31:0] v);
    @(negedge clk); sel = s; #1 v = rd;
  endtask

  task automatic clr_all();
    for (int r = 0; r < 8; r++) op(2'd1, 3'(r), 8'd0, 32'd0);
  endtask

  task automatic send(input logic [47:0] a, output logic v, output logic mm, output logic v_next);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); av = 1'b1; af = (i == 0); ab = a[47-8*i -: 8];
    end
    @(negedge clk); av = 1'b0; af = 1'b0; v = mv; mm = m;
    @(negedge clk); v_next = mv;
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v32;
    logic v, mm, vn;
    logic [47:0] a, b;
    logic [7:0] h, hb;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state
    for (int r = 0; r < 8; r++) begin
      rdreg(3'(r), v32);
      chk(v32 == 0, "R3 reset reg", v32, 0);
    end
    send(48'h01005e000001, v, mm, vn);
    chk(v == 1'b1 && mm == 1'b0, "R3 no match after reset", {v, mm}, 2'b10);

    // R2 R4 R5 entry position sweep
    for (int e = 0; e < 256; e++) begin
      op(2'd2, 3'd0, 8'(e), 32'd0);
      rdreg(3'(e >> 5), v32);
      chk(v32 == (32'h1 << (31 - (e % 32))), "R4 R2 set entry", v32, 32'h1 << (31 - (e % 32)));
      op(2'd3, 3'd0, 8'(e), 32'd0);
      rdreg(3'(e >> 5), v32);
      chk(v32 == 0, "R5 clear entry", v32, 0);
    end

    // R6 word write and readback
    for (int r = 0; r < 8; r++) op(2'd1, 3'(r), 8'd0, 32'hA5C3_0000 | 32'(r * 17));
    for (int r = 0; r < 8; r++) begin
      rdreg(3'(r), v32);
      chk(v32 == (32'hA5C3_0000 | 32'(r * 17)), "R6 word write", v32, 32'hA5C3_0000 | 32'(r * 17));
    end

    // R1 R2 R8 hash sweep over group addresses
    clr_all();
    for (int i = 0; i < 256; i++) begin
      a = {8'h01, 8'h00, 8'h5e, 8'(i), 8'(i) ^ 8'hA5, 8'h10};
      h = ref_hash(a);
      op(2'd2, 3'd0, h, 32'd0);
      send(a, v, mm, vn);
      chk(v && mm, "R1 R8 hash match", {v, mm}, 2'b11);
      chk(!vn, "R8 one-cycle strobe", vn, 0);
      op(2'd3, 3'd0, h, 32'd0);
      // R5: clearing inside a full register keeps the rest
      op(2'd1, h[7:5], 8'd0, 32'hFFFF_FFFF);
      op(2'd3, 3'd0, h, 32'd0);
      send(a, v, mm, vn);
      chk(v && !mm, "R5 cleared entry rejects", {v, mm}, 2'b10);
      rdreg(h[7:5], v32);
      chk(v32 == ~(32'h1 << (31 - h[4:0])), "R5 others kept", v32, ~(32'h1 << (31 - h[4:0])));
      op(2'd1, h[7:5], 8'd0, 32'd0);
    end

    // R7 individual address rejected with full table
    for (int r = 0; r < 8; r++) op(2'd1, 3'(r), 8'd0, 32'hFFFF_FFFF);
    send(48'h001122334455, v, mm, vn);
    chk(v && !mm, "R7 individual rejected", {v, mm}, 2'b10);
    send(48'h031122334455, v, mm, vn);
    chk(v && mm, "R7 group accepted", {v, mm}, 2'b11);

    // R11 idle keeps table
    repeat (5) @(negedge clk);
    rdreg(3'd4, v32);
    chk(v32 == 32'hFFFF_FFFF, "R11 idle keeps table", v32, 32'hFFFF_FFFF);

    // R9 restart discards partial address
    clr_all();
    a = 48'h0180C2000000;
    b = 48'h3300AABBCCDD;
    hb = ref_hash(b);
    op(2'd2, 3'd0, hb, 32'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); av = 1'b1; af = (i == 0); ab = a[47-8*i -: 8];
    end
    send(b, v, mm, vn);
    chk(v && mm, "R9 restart hash", {v, mm}, 2'b11);

    // R10 stray bytes after sixth and with no frame
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); av = 1'b1; af = 1'b0; ab = 8'(i);
      #1 chk(!mv, "R10 stray byte ignored", mv, 0);
    end
    @(negedge clk); av = 1'b0;
    chk(!mv, "R10 no strobe", mv, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule